// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block sits between a host CPU's register bus and a PCI-side request port. Software uses it to issue configuration reads and writes to devices on the bus, and to reach the host bridge's own local configuration space. For a remote access, software first writes a target descriptor with bus, slot, function and register offset. It may then write the write data. A final write to the command register gives the direction and the access size and starts the cycle. A local access is started the same way through its own command register. The block builds the bus address and the command code. It looks up the active-low byte-lane enables for the size and offset, shifts the write data onto its lanes, and holds a request on the PCI-side port until a response comes back.

On a response, read data is shifted down to bit 0 and masked to the access width. A master abort instead returns all ones and logs the failing address in the PCI error registers. A size/offset combination that has no legal lane pattern is never issued. It is logged in the host-bus error registers. Each error status bit is cleared by writing a one to it.

Register map (byte offsets on `reg_addr`):

| Offset | Write | Read |
|--------|-------|------|
| 0x00 | local command | formed local command word |
| 0x04 | local write data | local write data |
| 0x08 | (none) | local read data |
| 0x0C | remote target descriptor | formed remote address |
| 0x10 | remote command | formed remote command and byte enables |
| 0x14 | remote write data | remote write data |
| 0x18 | (none) | remote read data |
| 0x1C | PCI error status, write one to clear | PCI error status |
| 0x20 | (none) | PCI error address |
| 0x24 | host-bus error status, write one to clear | host-bus error status |
| 0x28 | (none) | host-bus error address |

Top module: `cfg_access_bridge`

## Requirements
- R1: After reset, `busy` and `req_valid` are 0, and both error status registers and both error address registers read 0.
- R2: The target descriptor at 0x0C holds the bus in bits 23:16, the slot in 15:11, the function in 10:8 and the register offset in 7:0. When the bus is 0, the formed address (read at 0x0C and driven on `req_addr`) has bit number `slot` set, the function in bits 10:8, the offset with bits 1:0 cleared in bits 7:0, and bits 1:0 equal to 0.
- R3: When the bus is nonzero, the formed address is (bus<<16) | (slot<<11) | (func<<8) | (offset & 0xFC) | 1.
- R4: A remote command write (bits 2:0 size, bit 8 write) issues `req_cmd` 0xA for a read or 0xB for a write. The byte enables are active low: for size 1 at lanes 0 to 3 they are 0xE, 0xD, 0xB, 0x7; for size 2 at lanes 0 and 2 they are 0xC and 0x3; for size 4 at lane 0 they are 0x0. Offset 0x10 reads back (be<<4) | cmd.
- R5: A command whose size and lane have no entry in that table is not issued: `busy` stays 0. Host-bus error status bit 0 (0x24) is set, and the formed address is captured at 0x28.
- R6: `req_wdata` is the write data register shifted left by 8 × (offset & 3).
- R7: Read data is the response shifted right by 8 × (offset & 3), then masked to 8, 16 or 32 bits by the size. Remote read data is stored at 0x18, local read data at 0x08.
- R8: A response with `rsp_abort` makes the stored read data 0xFFFFFFFF. It sets PCI error status bit 0 for a remote access or bit 1 for a local one, and captures `req_addr` at 0x20.
- R9: Writing a one to an error status bit clears it; writing a zero leaves it unchanged.
- R10: A started command holds `busy` and `req_valid` high, with stable request fields, until `rsp_ready`; the cycle after it, `busy` is 0. Command writes made while busy are ignored.
- R11: A local command (bits 7:0 offset, 10:8 size, bit 16 write) drives `req_local` = 1. Its formed word, on `req_addr` and read at 0x00, has bit 16 set for a write, the byte enables in bits 23:20 and the offset with bits 1:0 cleared in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| busy | output | 1 | A configuration cycle is outstanding |
| req_valid | output | 1 | PCI-side request valid |
| req_local | output | 1 | Request targets the local configuration space |
| req_addr | output | 32 | Formed configuration address or local command word |
| req_cmd | output | 4 | Command code, 0xA read or 0xB write |
| req_be | output | 4 | Active-low byte-lane enables |
| req_wdata | output | 32 | Lane-shifted write data |
| rsp_ready | input | 1 | Response pulse from the PCI side |
| rsp_rdata | input | 32 | Response read data |
| rsp_abort | input | 1 | Master-abort flag with the response |

## Verification
The checker watches every cycle for the handshake rules. A pending request keeps its address, command and lanes until the response, `busy` drops after it, and every issued lane pattern and command code is legal. Each remote abort sets PCI error bit 0, and each bus-0 address carries at most one bit above bit 10. The exact address encodings for type 0, type 1 and local accesses, the data shifting and masking, and the all-ones return are shown only by the bench's scenarios. So are the ignored command writes while busy, the rejection of illegal lanes and the write-one-to-clear behaviour. Those scenarios compare the values at the register ports and on the request port against values worked out from the requirements.

// File: rtl/cab_pkg.sv
package cab_pkg;
    localparam int DW = 32;
    localparam int RAW = 6;

    localparam logic [RAW-1:0] OFF_LCMD  = 6'h00;
    localparam logic [RAW-1:0] OFF_LWD   = 6'h04;
    localparam logic [RAW-1:0] OFF_LRD   = 6'h08;
    localparam logic [RAW-1:0] OFF_TGT   = 6'h0C;
    localparam logic [RAW-1:0] OFF_RCMD  = 6'h10;
    localparam logic [RAW-1:0] OFF_RWD   = 6'h14;
    localparam logic [RAW-1:0] OFF_RRD   = 6'h18;
    localparam logic [RAW-1:0] OFF_PST   = 6'h1C;
    localparam logic [RAW-1:0] OFF_PADR  = 6'h20;
    localparam logic [RAW-1:0] OFF_HST   = 6'h24;
    localparam logic [RAW-1:0] OFF_HADR  = 6'h28;

    typedef enum logic [3:0] {
        CMD_CFG_RD = 4'hA,
        CMD_CFG_WR = 4'hB
    } cfg_cmd_e;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] slot;
        logic [2:0] func;
        logic [7:0] reg_off;
    } target_t;

    typedef struct packed {
        logic       wr;
        logic       is_local;
        logic [2:0] size;
        logic [1:0] lane;
    } xfer_t;

    // returns {illegal, active-low byte enables}
    function automatic logic [4:0] lane_enables(input logic [2:0] size, input logic [1:0] lane);
        logic [4:0] r;
        r = 5'h1F;
        case (size)
            3'd1: case (lane)
                2'd0: r = 5'h0E;
                2'd1: r = 5'h0D;
                2'd2: r = 5'h0B;
                default: r = 5'h07;
            endcase
            3'd2: if (lane == 2'd0) r = 5'h0C; else if (lane == 2'd2) r = 5'h03;
            3'd4: if (lane == 2'd0) r = 5'h00;
            default: r = 5'h1F;
        endcase
        return r;
    endfunction

    function automatic logic [DW-1:0] form_cfg_addr(input target_t t);
        logic [DW-1:0] a;
        if (t.bus == 8'd0)
            a = (DW'(1) << t.slot) | (DW'(t.func) << 8) | DW'({t.reg_off[7:2], 2'b00});
        else
            a = (DW'(t.bus) << 16) | (DW'(t.slot) << 11) | (DW'(t.func) << 8)
              | DW'({t.reg_off[7:2], 2'b01});
        return a;
    endfunction

    function automatic logic [DW-1:0] form_local_word(input logic wr, input logic [3:0] be,
                                                      input logic [7:0] off);
        return {8'd0, be, 3'd0, wr, 8'd0, off[7:2], 2'b00};
    endfunction
endpackage

// File: rtl/cab_lane_shift.sv
module cab_lane_shift #(
    parameter int DW = 32
) (
    input  logic [1:0]    lane,
    input  logic [2:0]    size,
    input  logic [DW-1:0] wr_raw,
    input  logic [DW-1:0] rd_bus,
    output logic [DW-1:0] wr_bus,
    output logic [DW-1:0] rd_val
);
    localparam int SHW = 5;
    logic [SHW-1:0] sh;
    logic [DW-1:0]  mask;

    assign sh     = {lane, 3'b000};
    assign wr_bus = wr_raw << sh;

    always_comb begin
        case (size)
            3'd1:    mask = {{(DW-8){1'b0}}, 8'hFF};
            3'd2:    mask = {{(DW-16){1'b0}}, 16'hFFFF};
            3'd4:    mask = '1;
            default: mask = '0;
        endcase
    end

    assign rd_val = (rd_bus >> sh) & mask;
endmodule

// File: rtl/cab_err_log.sv
module cab_err_log #(
    parameter int W  = 2,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  set_vec,
    input  logic [AW-1:0] set_addr,
    input  logic          clr_wr,
    input  logic [W-1:0]  clr_vec,
    output logic [W-1:0]  status,
    output logic [AW-1:0] addr
);
    logic [W-1:0] clr_eff;
    assign clr_eff = clr_wr ? clr_vec : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            addr   <= '0;
        end else begin
            status <= (status & ~clr_eff) | set_vec;
            if (|set_vec) addr <= set_addr;
        end
    end
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
    import cab_pkg::*;
#(
    parameter int PERR_W = 2,
    parameter int HERR_W = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [5:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          busy,
    output logic          req_valid,
    output logic          req_local,
    output logic [31:0]   req_addr,
    output logic [3:0]    req_cmd,
    output logic [3:0]    req_be,
    output logic [31:0]   req_wdata,
    input  logic          rsp_ready,
    input  logic [31:0]   rsp_rdata,
    input  logic          rsp_abort
);
    target_t        tgt_q;
    logic [2:0]     rsize_q;
    logic           rwr_q;
    logic [7:0]     loff_q;
    logic [2:0]     lsize_q;
    logic           lwr_q;
    logic [DW-1:0]  lwd_q, rwd_q, lrd_q, rrd_q;
    logic           busy_q;
    xfer_t          cur_q;
    logic [DW-1:0]  raddr_q, rwdata_q;
    logic [3:0]     rcmd_q, rbe_q;

    // incoming command decode
    logic           wr_lcmd, wr_rcmd;
    logic [4:0]     r_new_lu, l_new_lu, r_st_lu, l_st_lu;
    logic           r_go, r_bad, l_go, l_bad;
    logic [DW-1:0]  tgt_addr, l_new_word;
    xfer_t          nxt;
    logic [DW-1:0]  shift_wr_bus, shift_rd_val;
    logic [1:0]     sh_lane;
    logic [2:0]     sh_size;
    logic           rsp_hit;
    logic [PERR_W-1:0] perr_set, pci_st;
    logic [HERR_W-1:0] herr_set, hb_st;
    logic [DW-1:0]  perr_addr, herr_addr, herr_cap;

    assign wr_lcmd    = reg_wr && (reg_addr == OFF_LCMD) && !busy_q;
    assign wr_rcmd    = reg_wr && (reg_addr == OFF_RCMD) && !busy_q;
    assign r_new_lu   = lane_enables(reg_wdata[2:0], tgt_q.reg_off[1:0]);
    assign l_new_lu   = lane_enables(reg_wdata[10:8], reg_wdata[1:0]);
    assign r_st_lu    = lane_enables(rsize_q, tgt_q.reg_off[1:0]);
    assign l_st_lu    = lane_enables(lsize_q, loff_q[1:0]);
    assign r_go       = wr_rcmd && !r_new_lu[4];
    assign r_bad      = wr_rcmd &&  r_new_lu[4];
    assign l_go       = wr_lcmd && !l_new_lu[4];
    assign l_bad      = wr_lcmd &&  l_new_lu[4];
    assign tgt_addr   = form_cfg_addr(tgt_q);
    assign l_new_word = form_local_word(reg_wdata[16], l_new_lu[3:0], reg_wdata[7:0]);

    always_comb begin
        nxt = '0;
        if (wr_lcmd) begin
            nxt.wr       = reg_wdata[16];
            nxt.is_local = 1'b1;
            nxt.size     = reg_wdata[10:8];
            nxt.lane     = reg_wdata[1:0];
        end else begin
            nxt.wr       = reg_wdata[8];
            nxt.is_local = 1'b0;
            nxt.size     = reg_wdata[2:0];
            nxt.lane     = tgt_q.reg_off[1:0];
        end
    end

    // one shifter serves issue (idle) and response (busy)
    assign sh_lane = busy_q ? cur_q.lane : nxt.lane;
    assign sh_size = busy_q ? cur_q.size : nxt.size;

    cab_lane_shift #(.DW(DW)) u_shift (
        .lane   (sh_lane),
        .size   (sh_size),
        .wr_raw (wr_lcmd ? lwd_q : rwd_q),
        .rd_bus (rsp_rdata),
        .wr_bus (shift_wr_bus),
        .rd_val (shift_rd_val)
    );

    assign rsp_hit = busy_q && rsp_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q    <= '0;
            rsize_q  <= '0;
            rwr_q    <= 1'b0;
            loff_q   <= '0;
            lsize_q  <= '0;
            lwr_q    <= 1'b0;
            lwd_q    <= '0;
            rwd_q    <= '0;
            lrd_q    <= '0;
            rrd_q    <= '0;
            busy_q   <= 1'b0;
            cur_q    <= '0;
            raddr_q  <= '0;
            rwdata_q <= '0;
            rcmd_q   <= '0;
            rbe_q    <= '0;
        end else begin
            if (reg_wr && reg_addr == OFF_TGT) tgt_q <= reg_wdata[$bits(target_t)-1:0];
            if (reg_wr && reg_addr == OFF_LWD) lwd_q <= reg_wdata;
            if (reg_wr && reg_addr == OFF_RWD) rwd_q <= reg_wdata;
            if (wr_rcmd) begin
                rsize_q <= reg_wdata[2:0];
                rwr_q   <= reg_wdata[8];
            end
            if (wr_lcmd) begin
                loff_q  <= reg_wdata[7:0];
                lsize_q <= reg_wdata[10:8];
                lwr_q   <= reg_wdata[16];
            end
            if (r_go || l_go) begin
                busy_q   <= 1'b1;
                cur_q    <= nxt;
                raddr_q  <= l_go ? l_new_word : tgt_addr;
                rcmd_q   <= nxt.wr ? CMD_CFG_WR : CMD_CFG_RD;
                rbe_q    <= l_go ? l_new_lu[3:0] : r_new_lu[3:0];
                rwdata_q <= shift_wr_bus;
            end
            if (rsp_hit) begin
                busy_q <= 1'b0;
                if (!cur_q.wr) begin
                    if (cur_q.is_local) lrd_q <= rsp_abort ? '1 : shift_rd_val;
                    else                rrd_q <= rsp_abort ? '1 : shift_rd_val;
                end
            end
        end
    end

    // error logs
    assign perr_set = PERR_W'({rsp_hit && rsp_abort && cur_q.is_local,
                               rsp_hit && rsp_abort && !cur_q.is_local});
    assign herr_set = HERR_W'(r_bad || l_bad);
    assign herr_cap = l_bad ? l_new_word : tgt_addr;

    cab_err_log #(.W(PERR_W), .AW(DW)) u_perr (
        .clk(clk), .rst(rst), .set_vec(perr_set), .set_addr(raddr_q),
        .clr_wr(reg_wr && reg_addr == OFF_PST), .clr_vec(reg_wdata[PERR_W-1:0]),
        .status(pci_st), .addr(perr_addr)
    );

    cab_err_log #(.W(HERR_W), .AW(DW)) u_herr (
        .clk(clk), .rst(rst), .set_vec(herr_set), .set_addr(herr_cap),
        .clr_wr(reg_wr && reg_addr == OFF_HST), .clr_vec(reg_wdata[HERR_W-1:0]),
        .status(hb_st), .addr(herr_addr)
    );

    // register read mux
    always_comb begin
        case (reg_addr)
            OFF_LCMD: reg_rdata = form_local_word(lwr_q, l_st_lu[3:0], loff_q);
            OFF_LWD:  reg_rdata = lwd_q;
            OFF_LRD:  reg_rdata = lrd_q;
            OFF_TGT:  reg_rdata = tgt_addr;
            OFF_RCMD: reg_rdata = {24'd0, r_st_lu[3:0], (rwr_q ? CMD_CFG_WR : CMD_CFG_RD)};
            OFF_RWD:  reg_rdata = rwd_q;
            OFF_RRD:  reg_rdata = rrd_q;
            OFF_PST:  reg_rdata = DW'(pci_st);
            OFF_PADR: reg_rdata = perr_addr;
            OFF_HST:  reg_rdata = DW'(hb_st);
            OFF_HADR: reg_rdata = herr_addr;
            default:  reg_rdata = '0;
        endcase
    end

    assign busy      = busy_q;
    assign req_valid = busy_q;
    assign req_local = cur_q.is_local;
    assign req_addr  = raddr_q;
    assign req_cmd   = rcmd_q;
    assign req_be    = rbe_q;
    assign req_wdata = rwdata_q;
endmodule

// File: rtl/cab_chk.sv
module cab_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        req_valid,
    input logic        req_local,
    input logic [31:0] req_addr,
    input logic [3:0]  req_cmd,
    input logic [3:0]  req_be,
    input logic        rsp_ready,
    input logic        rsp_abort,
    input logic [1:0]  pci_status
);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !rsp_ready |=> req_valid && $stable(req_addr) && $stable(req_be) && $stable(req_cmd));

    // R10
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        busy && rsp_ready |=> !busy);

    // R4
    be_legal_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_be == 4'hE || req_be == 4'hD || req_be == 4'hB || req_be == 4'h7 ||
                       req_be == 4'hC || req_be == 4'h3 || req_be == 4'h0));

    // R4
    cmd_code_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_cmd == 4'hA || req_cmd == 4'hB));

    // R8
    abort_flag_chk: assert property (@(posedge clk) disable iff (rst)
        busy && rsp_ready && rsp_abort && !req_local |=> pci_status[0]);

    // R2
    idsel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_local && !req_addr[0] |-> $countones(req_addr[31:11]) <= 1);
endmodule

bind cfg_access_bridge cab_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .req_valid(req_valid), .req_local(req_local),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be), .rsp_ready(rsp_ready),
    .rsp_abort(rsp_abort), .pci_status(pci_st)
);

// File: tb/cfg_access_bridge_tb.sv
module cfg_access_bridge_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, req_valid, req_local;
    logic [31:0] req_addr, req_wdata;
    logic [3:0]  req_cmd, req_be;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_rdata = '0;
    logic        rsp_abort = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cfg_access_bridge u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .busy(busy), .req_valid(req_valid), .req_local(req_local),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_abort(rsp_abort)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic respond(input logic [31:0] d, input logic ab);
        @(negedge clk);
        rsp_ready = 1'b1; rsp_rdata = d; rsp_abort = ab;
        @(negedge clk);
        rsp_ready = 1'b0; rsp_abort = 1'b0;
    endtask

    function automatic logic [31:0] tgt(input int bus, input int slot, input int fn, input int off);
        return (32'(bus) << 16) | (32'(slot) << 11) | (32'(fn) << 8) | 32'(off);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 req_valid", {31'd0, req_valid}, 0);
        rd(6'h1C, v); check("R1 pci status", v, 0);
        rd(6'h24, v); check("R1 hb status", v, 0);
        rd(6'h20, v); check("R1 pci addr", v, 0);
        rd(6'h28, v); check("R1 hb addr", v, 0);
    endtask

    task automatic t_addr_forms();
        logic [31:0] v;
        wr(6'h0C, tgt(0, 17, 2, 8'h44));
        rd(6'h0C, v); check("R2 type0 addr", v, 32'h0002_0244);
        wr(6'h0C, tgt(3, 5, 1, 8'h13));
        rd(6'h0C, v); check("R3 type1 addr", v, 32'h0003_2911);
    endtask

    task automatic t_remote_read_byte();
        logic [31:0] v;
        wr(6'h0C, tgt(0, 12, 0, 8'h46));
        wr(6'h10, 32'h0000_0001);
        check("R10 busy set", {31'd0, busy}, 1);
        check("R2 req_addr", req_addr, 32'h0000_1044);
        check("R4 cmd read", {28'd0, req_cmd}, 32'hA);
        check("R4 be size1 lane2", {28'd0, req_be}, 32'hB);
        check("R2 req_local", {31'd0, req_local}, 0);
        rd(6'h10, v); check("R4 cmd readback", v, 32'hBA);
        respond(32'hAABB_CCDD, 1'b0);
        check("R10 busy clear", {31'd0, busy}, 0);
        rd(6'h18, v); check("R7 byte read", v, 32'hBB);
    endtask

    task automatic t_remote_write_half();
        wr(6'h0C, tgt(1, 2, 3, 8'h42));
        wr(6'h14, 32'h0000_1234);
        wr(6'h10, 32'h0000_0102);
        check("R4 cmd write", {28'd0, req_cmd}, 32'hB);
        check("R4 be size2 lane2", {28'd0, req_be}, 32'h3);
        check("R6 wdata shift", req_wdata, 32'h1234_0000);
        check("R3 req_addr", req_addr, 32'h0001_1341);
        respond(32'h0, 1'b0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(6'h0C, tgt(0, 20, 0, 8'h40));
        wr(6'h10, 32'h0000_0004);
        wr(6'h10, 32'h0000_0101);
        check("R10 cmd held", {28'd0, req_cmd}, 32'hA);
        check("R10 be held", {28'd0, req_be}, 32'h0);
        rd(6'h10, v); check("R10 cmd reg ignored", v, 32'h0A);
        respond(32'h1122_3344, 1'b0);
        rd(6'h18, v); check("R7 word read", v, 32'h1122_3344);
    endtask

    task automatic t_abort_w1c();
        logic [31:0] v;
        wr(6'h0C, tgt(0, 9, 1, 8'h42));
        wr(6'h10, 32'h0000_0002);
        respond(32'h5555_5555, 1'b1);
        rd(6'h18, v); check("R8 all ones", v, 32'hFFFF_FFFF);
        rd(6'h1C, v); check("R8 pci bit0", v, 32'h1);
        rd(6'h20, v); check("R8 pci addr", v, 32'h0000_0340);
        wr(6'h1C, 32'h0);
        rd(6'h1C, v); check("R9 zero keeps", v, 32'h1);
        wr(6'h1C, 32'h1);
        rd(6'h1C, v); check("R9 one clears", v, 32'h0);
    endtask

    task automatic t_illegal();
        logic [31:0] v;
        wr(6'h0C, tgt(2, 4, 0, 8'h21));
        wr(6'h10, 32'h0000_0002);
        check("R5 not busy", {31'd0, busy}, 0);
        check("R5 no request", {31'd0, req_valid}, 0);
        rd(6'h24, v); check("R5 hb status", v, 32'h1);
        rd(6'h28, v); check("R5 hb addr", v, 32'h0002_2021);
        wr(6'h24, 32'h1);
        rd(6'h24, v); check("R9 hb clear", v, 32'h0);
    endtask

    task automatic t_local();
        logic [31:0] v;
        wr(6'h04, 32'h0000_00AB);
        wr(6'h00, 32'h0001_0107);
        check("R11 req_local", {31'd0, req_local}, 1);
        check("R11 local word", req_addr, 32'h0071_0004);
        check("R6 local wdata", req_wdata, 32'hAB00_0000);
        rd(6'h00, v); check("R11 local readback", v, 32'h0071_0004);
        respond(32'h0, 1'b0);
        wr(6'h00, 32'h0000_0408);
        check("R11 local read word", req_addr, 32'h0000_0008);
        respond(32'hCAFE_F00D, 1'b0);
        rd(6'h08, v); check("R7 local read", v, 32'hCAFE_F00D);
        wr(6'h00, 32'h0000_0200);
        respond(32'h0, 1'b1);
        rd(6'h08, v); check("R8 local all ones", v, 32'hFFFF_FFFF);
        rd(6'h1C, v); check("R8 pci bit1", v, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_addr_forms();
        t_remote_read_byte();
        t_remote_write_half();
        t_busy_ignore();
        t_abort_w1c();
        t_illegal();
        t_local();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule